// File: doc/BRIEF.md
# Key-Protected Watchdog Timer

This block is a watchdog timer reached through a small 32-bit register interface. A 16-bit up-counter advances once per prescaled tick, and the tick rate comes from a fixed set of clock dividers. When the count wraps from its top value back to zero, the block raises a sticky overflow flag and pulses a reset-request output for one cycle. A system reset controller elsewhere acts on that pulse.

Software keeps the system alive by reloading the counter before it wraps. The timeout is 65536 minus the loaded value, counted in prescaled ticks. Each register accepts a write only when that write carries the register's own key in its upper bits. A write with the wrong key changes nothing.

A counter load does not take effect at once. It passes through a fixed two-cycle synchronisation window. During that window a busy bit reads 1, and software should poll it before it sets the enable bit. While a load is pending, the counter and the prescaler are both held.

Top module: `kwdt_top`

## Requirements
- R1: After reset, the count is 0, the control word reads 0 (counting off, divider index 0, both flags clear) and `reset_req` is low.
- R2: A write to byte offset 0 is accepted only when `bus_wdata[31:16]` equals 0x5A5A. The load value is `bus_wdata[15:0]`. A write to offset 0 with any other key leaves the count, the busy bit and the prescaler unchanged.
- R3: A write to byte offset 4 is accepted only when `bus_wdata[31:8]` equals 0xA5A5A5. The new control fields come from `bus_wdata[7:0]`. A write to offset 4 with any other key leaves the control word unchanged.
- R4: After an accepted counter write, the busy bit (control bit 5) reads 1 for exactly two cycles. The loaded value becomes visible on the second clock edge after the write edge. The write also restarts the prescaler from zero, and the prescaler and counter stay held until the load completes.
- R5: The counter advances only while the enable bit (control bit 7) is 1. While the enable bit is 0 and no load is pending, the count holds.
- R6: Control bits 2:0 select the divide ratio: 0→1, 1→4, 2→16, 3→32, 4→64, 5→128, 6→1024. Values 7 and above also give 1024. While counting is enabled, the count rises by one after every N enabled cycles, where N is the selected ratio.
- R7: When an enabled tick takes the count from 0xFFFF to 0x0000, the overflow flag (control bit 4) is set and `reset_req` is high for exactly the following cycle.
- R8: The overflow flag is sticky. An accepted control write with bit 4 equal to 0 clears it. An accepted control write with bit 4 equal to 1 leaves it as it is. If a wrap happens on the same edge as a clearing write, the flag is set.
- R9: Reading offset 0 returns `{16'h0, count}`. Reading offset 4 returns the control word: bit 7 enable, bit 5 busy, bit 4 overflow, bits 2:0 divider index, all other bits 0. Reading any other offset returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one access per cycle |
| bus_addr | input | 3 | Byte offset of the access |
| bus_wdata | input | 32 | Write data, including the key bits |
| bus_rdata | output | 32 | Combinational read data for `bus_addr` |
| reset_req | output | 1 | One-cycle reset request issued on a counter wrap |

## Verification
The assertions assume that all inputs change only between clock edges and that the write strobe is a single-cycle level. They also assume the bus address is a plain byte offset, not a qualified read. The bench drives every input a short delay after the falling edge and holds it across the next rising edge. It issues at most one write per cycle. It reads the outputs combinationally in the second half of the cycle, so the properties see only settled values.

// File: rtl/kwdt_pkg.sv
package kwdt_pkg;

  localparam int unsigned DATA_W   = 32;
  localparam int unsigned ADDR_W   = 3;
  localparam int unsigned CNT_W    = 16;
  localparam int unsigned SEL_W    = 3;
  localparam int unsigned MAX_DIV  = 1024;
  localparam int unsigned SYNC_CYC = 2;

  localparam logic [ADDR_W-1:0] OFS_COUNT = 3'd0;
  localparam logic [ADDR_W-1:0] OFS_CTRL  = 3'd4;

  localparam logic [15:0] KEY_COUNT = 16'h5A5A;
  localparam logic [23:0] KEY_CTRL  = 24'hA5A5A5;

  localparam int unsigned BIT_EN   = 7;
  localparam int unsigned BIT_BUSY = 5;
  localparam int unsigned BIT_OVF  = 4;

  // Divide ratio picked by a selector value; out-of-range selectors use the slowest ratio.
  function automatic int unsigned div_of(input logic [SEL_W-1:0] s);
    case (s)
      3'd0:    div_of = 1;
      3'd1:    div_of = 4;
      3'd2:    div_of = 16;
      3'd3:    div_of = 32;
      3'd4:    div_of = 64;
      3'd5:    div_of = 128;
      default: div_of = MAX_DIV;
    endcase
  endfunction

  function automatic logic count_key_ok(input logic [DATA_W-1:0] d);
    return d[31:16] == KEY_COUNT;
  endfunction

  function automatic logic ctrl_key_ok(input logic [DATA_W-1:0] d);
    return d[31:8] == KEY_CTRL;
  endfunction

endpackage

// File: rtl/kwdt_prescaler.sv
module kwdt_prescaler
  import kwdt_pkg::*;
#(
  parameter int unsigned PRE_DIV_MAX = MAX_DIV,
  localparam int unsigned PRE_W = $clog2(PRE_DIV_MAX) + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             run,
  input  logic [SEL_W-1:0] sel,
  output logic             tick
);

  logic [PRE_W-1:0] pre_q;
  logic [PRE_W-1:0] limit;

  always_comb begin
    limit = PRE_W'(div_of(sel) - 1);
    tick  = run && !clear && (pre_q >= limit);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      pre_q <= '0;
    else if (clear)  pre_q <= '0;
    else if (run) begin
      if (tick) pre_q <= '0;
      else      pre_q <= pre_q + 1'b1;
    end
  end

endmodule

// File: rtl/kwdt_counter.sv
module kwdt_counter
  import kwdt_pkg::*;
#(
  parameter int unsigned W    = CNT_W,
  parameter int unsigned SYNC = SYNC_CYC,
  localparam int unsigned PW  = $clog2(SYNC + 1)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_req,
  input  logic [W-1:0] load_val,
  input  logic         tick,
  output logic [W-1:0] cnt_val,
  output logic         busy,
  output logic         ovf_evt
);

  logic [PW-1:0] pend_q;
  logic [W-1:0]  hold_q;
  logic [W-1:0]  cnt_q;

  assign busy    = (pend_q != '0);
  assign cnt_val = cnt_q;
  assign ovf_evt = tick && !busy && !load_req && (cnt_q == {W{1'b1}});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
      hold_q <= '0;
      cnt_q  <= '0;
    end else if (load_req) begin
      pend_q <= PW'(SYNC);
      hold_q <= load_val;
    end else if (busy) begin
      pend_q <= pend_q - 1'b1;
      if (pend_q == PW'(1)) cnt_q <= hold_q;
    end else if (tick) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

endmodule

// File: rtl/kwdt_regif.sv
module kwdt_regif
  import kwdt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic [CNT_W-1:0]  cnt_val,
  input  logic              busy,
  input  logic              ovf_evt,
  output logic              cnt_hit,
  output logic              ctl_hit,
  output logic [CNT_W-1:0]  load_val,
  output logic              tmr_en,
  output logic [SEL_W-1:0]  sel,
  output logic              ovf_flag,
  output logic [DATA_W-1:0] bus_rdata
);

  assign cnt_hit  = bus_wr && (bus_addr == OFS_COUNT) && count_key_ok(bus_wdata);
  assign ctl_hit  = bus_wr && (bus_addr == OFS_CTRL)  && ctrl_key_ok(bus_wdata);
  assign load_val = bus_wdata[CNT_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tmr_en <= 1'b0;
      sel    <= '0;
    end else if (ctl_hit) begin
      tmr_en <= bus_wdata[BIT_EN];
      sel    <= bus_wdata[SEL_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                            ovf_flag <= 1'b0;
    else if (ovf_evt)                      ovf_flag <= 1'b1;
    else if (ctl_hit && !bus_wdata[BIT_OVF]) ovf_flag <= 1'b0;
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == OFS_COUNT) begin
      bus_rdata[CNT_W-1:0] = cnt_val;
    end else if (bus_addr == OFS_CTRL) begin
      bus_rdata[BIT_EN]      = tmr_en;
      bus_rdata[BIT_BUSY]    = busy;
      bus_rdata[BIT_OVF]     = ovf_flag;
      bus_rdata[SEL_W-1:0]   = sel;
    end
  end

endmodule

// File: rtl/kwdt_top.sv
module kwdt_top
  import kwdt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              reset_req
);

  logic             cnt_hit;
  logic             ctl_hit;
  logic [CNT_W-1:0] load_val;
  logic             tmr_en;
  logic [SEL_W-1:0] sel;
  logic             ovf_flag;
  logic [CNT_W-1:0] cnt_val;
  logic             busy;
  logic             ovf_evt;
  logic             tick;
  logic             pre_run;
  logic             pre_clr;

  assign pre_run = tmr_en && !busy && !cnt_hit;
  assign pre_clr = cnt_hit || busy;

  kwdt_regif u_regif (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .cnt_val(cnt_val), .busy(busy), .ovf_evt(ovf_evt),
    .cnt_hit(cnt_hit), .ctl_hit(ctl_hit), .load_val(load_val), .tmr_en(tmr_en),
    .sel(sel), .ovf_flag(ovf_flag), .bus_rdata(bus_rdata)
  );

  kwdt_prescaler #(.PRE_DIV_MAX(MAX_DIV)) u_pre (
    .clk(clk), .rst_n(rst_n), .clear(pre_clr), .run(pre_run), .sel(sel), .tick(tick)
  );

  kwdt_counter #(.W(CNT_W), .SYNC(SYNC_CYC)) u_cnt (
    .clk(clk), .rst_n(rst_n), .load_req(cnt_hit), .load_val(load_val), .tick(tick),
    .cnt_val(cnt_val), .busy(busy), .ovf_evt(ovf_evt)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) reset_req <= 1'b0;
    else        reset_req <= ovf_evt;
  end

endmodule

// File: rtl/kwdt_checker.sv
module kwdt_checker
  import kwdt_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic [CNT_W-1:0] cnt_val,
  input logic             busy,
  input logic             tmr_en,
  input logic             ovf_flag,
  input logic             ovf_evt,
  input logic             tick,
  input logic             cnt_hit,
  input logic             ctl_hit,
  input logic             reset_req
);

  // R7: the request lasts a single cycle
  p_req_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    reset_req |=> !reset_req);

  // R7: a wrap raises the request and the flag on the next cycle
  p_wrap_effect_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_evt |=> (reset_req && ovf_flag && cnt_val == '0));

  // R4: an accepted load makes the busy bit visible
  p_load_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_hit |=> busy);

  // R4: no tick reaches the counter while a load is pending
  p_no_tick_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !tick);

  // R5: the count holds while counting is off and nothing is pending
  p_hold_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!tmr_en && !busy && !cnt_hit) |=> $stable(cnt_val));

  // R8: the flag is sticky unless a control write arrives
  p_flag_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_flag && !ctl_hit) |=> ovf_flag);

  // R7: the request only follows a wrap
  p_req_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(reset_req) |-> $past(ovf_evt));

endmodule

bind kwdt_top kwdt_checker u_chk (
  .clk(clk), .rst_n(rst_n), .cnt_val(cnt_val), .busy(busy), .tmr_en(tmr_en),
  .ovf_flag(ovf_flag), .ovf_evt(ovf_evt), .tick(tick), .cnt_hit(cnt_hit),
  .ctl_hit(ctl_hit), .reset_req(reset_req)
);

// File: tb/kwdt_top_tb.sv
module kwdt_top_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [2:0]  bus_addr = 3'd0;
  logic [31:0] bus_wdata = 32'd0;
  logic [31:0] bus_rdata;
  logic        reset_req;

  int checks = 0;
  int failures = 0;
  int cycles = 0;

  // reference state
  int m_cnt = 0, m_pre = 0, m_busy = 0, m_load = 0, m_sel = 0;
  bit m_en = 0, m_ovf = 0, m_req = 0;

  always #2.5 clk = ~clk;

  kwdt_top u_dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .reset_req(reset_req)
  );

  function automatic int ref_div(int s);
    if (s == 0) return 1;
    if (s == 1) return 4;
    if (s >= 6) return 1024;
    return 16 << (s - 2);
  endfunction

  function automatic logic [31:0] ref_read(int a);
    logic [31:0] v = 32'd0;
    if (a == 0) v[15:0] = m_cnt[15:0];
    else if (a == 4) begin
      v[7] = m_en; v[5] = (m_busy != 0); v[4] = m_ovf; v[2:0] = m_sel[2:0];
    end
    return v;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  // reference model, advanced on every rising edge
  always @(posedge clk) begin
    bit wc, wk, wrap;
    cycles++;
    if (!rst_n) begin
      m_cnt = 0; m_pre = 0; m_busy = 0; m_load = 0; m_sel = 0;
      m_en = 0; m_ovf = 0; m_req = 0;
    end else begin
      wc = bus_wr && bus_addr == 0 && bus_wdata[31:16] == 16'h5A5A;
      wk = bus_wr && bus_addr == 4 && bus_wdata[31:8] == 24'hA5A5A5;
      wrap = 0;
      if (wc) begin
        m_busy = 2; m_load = int'(bus_wdata[15:0]); m_pre = 0;
      end else if (m_busy > 0) begin
        m_busy--;
        if (m_busy == 0) m_cnt = m_load;
      end else if (m_en) begin
        if (m_pre + 1 >= ref_div(m_sel)) begin
          m_pre = 0;
          if (m_cnt == 65535) begin m_cnt = 0; wrap = 1; end
          else m_cnt++;
        end else m_pre++;
      end
      if (wk) begin
        m_en = bus_wdata[7];
        m_sel = int'(bus_wdata[2:0]);
        if (!bus_wdata[4]) m_ovf = 0;
      end
      if (wrap) m_ovf = 1;
      m_req = wrap;
    end
  end

  // per-cycle comparison in the second half of the cycle
  always @(negedge clk) begin
    if (rst_n) begin
      chk(reset_req == m_req, "R7 reset_req vs model", {31'd0, reset_req}, {31'd0, m_req});
      chk(bus_rdata == ref_read(int'(bus_addr)), "R9 readback vs model", bus_rdata, ref_read(int'(bus_addr)));
    end
  end

  initial begin
    forever begin
      @(posedge clk);
      if (cycles > 150000) begin
        failures++;
        $display("FAIL watchdog expired");
        summary();
      end
    end
  end

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); #1;
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); #1;
    bus_wr = 1'b0; bus_wdata = 32'd0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] v);
    bus_addr = a;
    #1;
    v = bus_rdata;
  endtask

  initial begin
    logic [31:0] v;
    logic [31:0] held;
    bit seen;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    idle(1);

    // R1 reset state
    rd(3'd0, v); chk(v == 0, "R1 count after reset", v, 0);
    rd(3'd4, v); chk(v == 0, "R1 ctrl after reset", v, 0);
    chk(reset_req == 0, "R1 reset_req low", {31'd0, reset_req}, 0);

    // R2 wrong key on counter write
    wr(3'd0, 32'h1234_00AB); idle(3);
    rd(3'd0, v); chk(v == 0, "R2 unkeyed count write ignored", v, 0);
    rd(3'd4, v); chk(v[5] == 0, "R2 unkeyed write sets no busy", v, 0);

    // R3 wrong key on control write
    wr(3'd4, 32'hA5A5_A487); idle(3);
    rd(3'd4, v); chk(v == 0, "R3 unkeyed ctrl write ignored", v, 0);

    // R4 load latency and busy bit
    wr(3'd0, 32'h5A5A_FFF0);
    rd(3'd4, v); chk(v[5] == 1, "R4 busy first cycle", v, 32'h20);
    idle(1);
    rd(3'd4, v); chk(v[5] == 1, "R4 busy second cycle", v, 32'h20);
    rd(3'd0, v); chk(v == 0, "R4 old count while pending", v, 0);
    idle(1);
    rd(3'd4, v); chk(v[5] == 0, "R4 busy cleared", v, 0);
    rd(3'd0, v); chk(v == 32'hFFF0, "R4 loaded value visible", v, 32'hFFF0);

    // R5 / R6 divide by 1
    wr(3'd4, 32'hA5A5_A580); idle(5);
    rd(3'd0, v); chk(v == 32'hFFF5, "R6 div1 counting", v, 32'hFFF5);

    // R7 wrap
    seen = 0;
    for (int i = 0; i < 40 && !seen; i++) begin
      if (reset_req) seen = 1; else idle(1);
    end
    chk(seen, "R7 reset_req pulse seen", {31'd0, seen}, 1);
    idle(1);
    chk(reset_req == 0, "R7 pulse one cycle", {31'd0, reset_req}, 0);
    rd(3'd4, v); chk(v[4] == 1, "R7 overflow flag set", v, 32'h90);

    // R5 disable, R8 flag kept by writing 1
    wr(3'd4, 32'hA5A5_A510);
    rd(3'd0, held); idle(8);
    rd(3'd0, v); chk(v == held, "R5 count holds when disabled", v, held);
    rd(3'd4, v); chk(v[4] == 1, "R8 flag kept when bit4=1", v, 32'h10);
    wr(3'd4, 32'hA5A5_A500);
    rd(3'd4, v); chk(v[4] == 0, "R8 flag cleared when bit4=0", v, 0);

    // R6 divide by 4
    wr(3'd0, 32'h5A5A_0000); idle(3);
    wr(3'd4, 32'hA5A5_A581); idle(40);
    rd(3'd0, v); chk(v == 10, "R6 div4 count", v, 10);

    // R6 divide by 16
    wr(3'd4, 32'hA5A5_A500);
    wr(3'd0, 32'h5A5A_0000); idle(3);
    wr(3'd4, 32'hA5A5_A582); idle(64);
    rd(3'd0, v); chk(v == 4, "R6 div16 count", v, 4);

    // R6 selector 7 acts as 1024
    wr(3'd4, 32'hA5A5_A500);
    wr(3'd0, 32'h5A5A_0000); idle(3);
    wr(3'd4, 32'hA5A5_A587); idle(2048);
    rd(3'd0, v); chk(v == 2, "R6 sel7 div1024 count", v, 2);
    rd(3'd4, v); chk(v[2:0] == 3'd7, "R6 sel7 readback", v, 32'h87);

    // R7 wrap through the prescaler, R4 prescaler restart on load
    wr(3'd4, 32'hA5A5_A500);
    wr(3'd0, 32'h5A5A_FFFF); idle(3);
    wr(3'd4, 32'hA5A5_A581); idle(3);
    chk(reset_req == 0, "R7 no request before wrap", {31'd0, reset_req}, 0);
    idle(1);
    chk(reset_req == 1, "R7 request at div4 wrap", {31'd0, reset_req}, 1);
    idle(1);
    chk(reset_req == 0, "R7 request ends", {31'd0, reset_req}, 0);
    idle(2);
    wr(3'd0, 32'h5A5A_0100); idle(2);
    rd(3'd0, v); chk(v == 32'h100, "R4 reload while running", v, 32'h100);
    idle(4);
    rd(3'd0, v); chk(v == 32'h101, "R4 prescaler restarted", v, 32'h101);

    // R9 unmapped offset and upper count bits
    rd(3'd2, v); chk(v == 0, "R9 unmapped offset reads 0", v, 0);
    rd(3'd0, v); chk(v[31:16] == 0, "R9 count upper bits 0", v, 0);

    idle(2);
    summary();
  end

endmodule